// File: doc/BRIEF.md
# Write-Protection Status Register

This block keeps the 8-bit status byte of a serial memory and decides, every cycle, whether a memory write to the presented address and a status-byte write are currently allowed. It holds a write-enable latch, a two-bit block-protect code, a status-lock bit and four free user bits. An external active-low write-protect input works together with the status-lock bit to guard the status byte itself.

The serial front end hands over one-cycle strobes that are already decoded: set the enable latch, clear it, and write the status byte with an 8-bit value. It also presents the address of a pending memory write. The block returns the status byte for read-back, a memory-write permit for that address and a status-write permit. Retaining the bits across power loss is modelled by reset values only.

Top module: `wprot_top`

## Requirements
- R1: After reset the status byte reads 0x00 and both permits are low.
- R2: Status layout: bit 7 is the status lock, bits 3:2 are the block-protect code (bit 3 high, bit 2 low), bit 1 is the enable latch. Bits 6, 5, 4 and 0 are stored and read back but never change either permit.
- R3: A set-enable strobe makes bit 1 read 1 from the next cycle. A clear-enable strobe makes it read 0 from the next cycle. When both come in the same cycle, clear wins.
- R4: While the enable latch is 0, both permits are low and a status-write strobe leaves the byte unchanged.
- R5: With the latch set, the memory permit is low for protected addresses and high elsewhere. Code 00 protects nothing. Code 01 protects addresses whose two top bits are 11. Code 10 protects addresses whose top bit is 1. Code 11 protects every address.
- R6: With the latch set, the status permit is high when the lock bit is 0 or the write-protect input is high. When the lock bit is 1 and the input is low, the permit is low and a status-write strobe is ignored.
- R7: An allowed status write takes effect in the cycle after its strobe. Permission is judged on the lock bit, latch and write-protect input of the strobe cycle. The written value replaces bits 7:2 and bit 0, and bit 1 keeps its own value.
- R8: The enable latch stays set across any number of accepted status writes and memory-permit checks until a clear-enable strobe or reset.
- R9: A status write in the same cycle as a clear strobe is judged with the latch still set: it is applied, and the latch ends at 0. A status write in the same cycle as a set strobe while the latch is 0 is rejected, and the latch ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n | input | 1 | Write-protect input; low guards a locked status byte |
| wen_set | input | 1 | One-cycle strobe: set the enable latch |
| wen_clr | input | 1 | One-cycle strobe: clear the enable latch |
| stat_wr | input | 1 | One-cycle strobe: write the status byte |
| stat_wdata | input | 8 | Value offered with the status write |
| mem_addr | input | ADDR_W (17) | Address of the pending memory write |
| stat_q | output | 8 | Current status byte |
| mem_wr_ok | output | 1 | Memory write to mem_addr is allowed |
| stat_wr_ok | output | 1 | Status write is allowed now |

## Verification
Two functions can land in one cycle: a latch command and a status write. The latch update and the permission decision for the write then both depend on the same latch bit. The bench drives a status write together with a clear strobe while the latch is set, and together with a set strobe while it is clear. It judges the outcome one cycle later from the read-back byte and both permits: the first write must land with the latch dropped, and the second must be discarded with the latch raised.

// File: rtl/wprot_pkg.sv
// Package: wprot_pkg
// Shared bit positions of the status byte and the protect-code type.
// Assumes an 8-bit status byte; bit positions are fixed by the command set.
package wprot_pkg;
    localparam int STAT_W  = 8;
    localparam int LOCK_B  = 7;
    localparam int BPH_B   = 3;
    localparam int BPL_B   = 2;
    localparam int WEL_B   = 1;

    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_e;
endpackage

// File: rtl/wprot_region.sv
// Module: wprot_region
// Decides whether an address lies in the region selected by the protect code.
// Assumes ADDR_W >= 2 so that the two top address bits exist.
module wprot_region #(
    parameter int ADDR_W = 17
) (
    input  wprot_pkg::prot_e   code,
    input  logic [ADDR_W-1:0]  addr,
    output logic               locked
);
    localparam int TOP = ADDR_W - 1;

    // Compare the top address bits against the selected fraction of the array.
    always_comb begin
        unique case (code)
            wprot_pkg::PROT_NONE:    locked = 1'b0;
            wprot_pkg::PROT_QUARTER: locked = &addr[TOP -: 2];
            wprot_pkg::PROT_HALF:    locked = addr[TOP];
            default:                 locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/wprot_policy.sv
// Module: wprot_policy
// Combines latch, lock bit, write-protect input and region result into permits.
// Assumes all inputs are stable within the cycle; purely combinational.
module wprot_policy (
    input  logic wel,
    input  logic lock,
    input  logic wp_n,
    input  logic region_locked,
    output logic mem_ok,
    output logic stat_ok
);
    // Memory writes need the latch and an unprotected address.
    always_comb mem_ok = wel & ~region_locked;

    // Status writes need the latch, and a locked byte needs the input high.
    always_comb stat_ok = wel & (~lock | wp_n);
endmodule

// File: rtl/wprot_stat_reg.sv
// Module: wprot_stat_reg
// Holds the status byte: the enable latch plus seven data-written bits.
// Assumes strobes are one cycle wide; wr_ok is judged on the strobe cycle.
module wprot_stat_reg (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wen_set,
    input  logic                          wen_clr,
    input  logic                          wr_stb,
    input  logic                          wr_ok,
    input  logic [wprot_pkg::STAT_W-1:0]  wr_data,
    output logic [wprot_pkg::STAT_W-1:0]  stat
);
    import wprot_pkg::*;

    logic                wel_q;
    logic [STAT_W-1:0]   body_q;
    logic [STAT_W-1:0]   body_mask;

    // Every bit except the latch is taken from the written value.
    always_comb begin
        body_mask        = '1;
        body_mask[WEL_B] = 1'b0;
    end

    // Enable latch: clear has priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel_q <= 1'b0;
        else if (wen_clr) wel_q <= 1'b0;
        else if (wen_set) wel_q <= 1'b1;
    end

    // Data-written bits: load on an allowed status write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 body_q <= '0;
        else if (wr_stb && wr_ok)   body_q <= wr_data & body_mask;
    end

    // Assemble the read-back byte.
    always_comb begin
        stat        = body_q;
        stat[WEL_B] = wel_q;
    end
endmodule

// File: rtl/wprot_top.sv
// Module: wprot_top
// Status byte with block write protection for a serial memory.
// Assumes decoded one-cycle command strobes from the serial front end.
module wprot_top #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              wen_set,
    input  logic              wen_clr,
    input  logic              stat_wr,
    input  logic [7:0]        stat_wdata,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        stat_q,
    output logic              mem_wr_ok,
    output logic              stat_wr_ok
);
    import wprot_pkg::*;

    logic  region_locked;
    prot_e code;

    // Extract the protect code from the status byte.
    always_comb code = prot_e'({stat_q[BPH_B], stat_q[BPL_B]});

    wprot_stat_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wen_set (wen_set),
        .wen_clr (wen_clr),
        .wr_stb  (stat_wr),
        .wr_ok   (stat_wr_ok),
        .wr_data (stat_wdata),
        .stat    (stat_q)
    );

    wprot_region #(.ADDR_W(ADDR_W)) u_region (
        .code   (code),
        .addr   (mem_addr),
        .locked (region_locked)
    );

    wprot_policy u_policy (
        .wel           (stat_q[WEL_B]),
        .lock          (stat_q[LOCK_B]),
        .wp_n          (wp_n),
        .region_locked (region_locked),
        .mem_ok        (mem_wr_ok),
        .stat_ok       (stat_wr_ok)
    );
endmodule

// File: rtl/wprot_checker.sv
// Module: wprot_checker
// Temporal checks on the ports of wprot_top; attached by bind below.
// Assumes the default 8-bit status layout.
module wprot_checker #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic              wen_set,
    input logic              wen_clr,
    input logic              stat_wr,
    input logic [7:0]        stat_wdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        stat_q,
    input logic              mem_wr_ok,
    input logic              stat_wr_ok
);
    p_set_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_set && !wen_clr) |=> stat_q[1]);

    p_clr_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wen_clr |=> !stat_q[1]);

    p_no_permit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q[1] |-> (!mem_wr_ok && !stat_wr_ok));

    p_all_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[3:2] == 2'b11) |-> !mem_wr_ok);

    p_locked_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[7] && !wp_n) |-> !stat_wr_ok);

    p_reject_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !stat_wr_ok) |=> ({stat_q[7:2], stat_q[0]} == $past({stat_q[7:2], stat_q[0]})));

    p_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_wr_ok) |=> ({stat_q[7:2], stat_q[0]} == $past({stat_wdata[7:2], stat_wdata[0]})));

    p_latch_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[1] && !wen_clr) |=> stat_q[1]);
endmodule

bind wprot_top wprot_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_n       (wp_n),
    .wen_set    (wen_set),
    .wen_clr    (wen_clr),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .mem_addr   (mem_addr),
    .stat_q     (stat_q),
    .mem_wr_ok  (mem_wr_ok),
    .stat_wr_ok (stat_wr_ok)
);

// File: tb/wprot_top_tb_top.sv
// Bench for wprot_top: a vector table walked by one loop, then directed tests.
module wprot_top_tb_top;
    localparam int ADDR_W = 17;
    localparam int VW     = 3 + 8 + 1 + ADDR_W + 8 + 2;
    localparam int NV     = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wp_n;
    logic              wen_set;
    logic              wen_clr;
    logic              stat_wr;
    logic [7:0]        stat_wdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        stat_q;
    logic              mem_wr_ok;
    logic              stat_wr_ok;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wprot_top #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wen_set(wen_set),
        .wen_clr(wen_clr), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .mem_addr(mem_addr), .stat_q(stat_q), .mem_wr_ok(mem_wr_ok),
        .stat_wr_ok(stat_wr_ok)
    );

    // Row: {set, clr, swr, data, wp_n, addr, exp_stat, exp_mem_ok, exp_stat_ok}
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'b001, 8'hFF, 1'b1, 17'h00000, 8'h00, 2'b00}, // 0  R4 write with latch clear
        {3'b100, 8'h00, 1'b1, 17'h00000, 8'h02, 2'b11}, // 1  R3 set latch
        {3'b001, 8'h04, 1'b1, 17'h18000, 8'h06, 2'b01}, // 2  R5 quarter, top quarter locked
        {3'b000, 8'h00, 1'b1, 17'h17FFF, 8'h06, 2'b11}, // 3  R5 quarter, just below
        {3'b001, 8'h08, 1'b1, 17'h10000, 8'h0A, 2'b01}, // 4  R5 half, upper half locked
        {3'b000, 8'h00, 1'b1, 17'h0FFFF, 8'h0A, 2'b11}, // 5  R5 half, lower half free
        {3'b001, 8'h0C, 1'b1, 17'h00000, 8'h0E, 2'b01}, // 6  R5 all locked
        {3'b001, 8'h71, 1'b1, 17'h1FFFF, 8'h73, 2'b11}, // 7  R2 R7 R8 user bits, latch kept
        {3'b001, 8'h80, 1'b0, 17'h00000, 8'h82, 2'b10}, // 8  R6 unlocked byte, write taken
        {3'b001, 8'h0C, 1'b0, 17'h00000, 8'h82, 2'b10}, // 9  R6 locked and input low, ignored
        {3'b001, 8'h8D, 1'b1, 17'h00000, 8'h8F, 2'b01}, // 10 R6 R7 locked, input high, taken
        {3'b010, 8'h00, 1'b1, 17'h00000, 8'h8D, 2'b00}, // 11 R3 clear latch
        {3'b001, 8'h00, 1'b1, 17'h00000, 8'h8D, 2'b00}, // 12 R4 rejected
        {3'b110, 8'h00, 1'b1, 17'h00000, 8'h8D, 2'b00}, // 13 R3 set and clear, clear wins
        {3'b101, 8'h00, 1'b1, 17'h00000, 8'h8F, 2'b01}, // 14 R9 set with write, write dropped
        {3'b011, 8'h00, 1'b1, 17'h00000, 8'h00, 2'b00}  // 15 R9 clear with write, write taken
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 12:        return "R4";
            1, 11, 13:    return "R3";
            2, 3, 4, 5, 6: return "R5";
            7:            return "R2/R7/R8";
            8, 9:         return "R6";
            10:           return "R6/R7";
            default:      return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v, input string what);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
        end
    endtask

    task automatic idle_inputs();
        wen_set = 1'b0; wen_clr = 1'b0; stat_wr = 1'b0; stat_wdata = '0;
    endtask

    task automatic check_all(input string req, input logic [7:0] es, input logic em, input logic eo);
        check(req, stat_q, es, "status");
        check(req, {7'd0, mem_wr_ok}, {7'd0, em}, "mem_wr_ok");
        check(req, {7'd0, stat_wr_ok}, {7'd0, eo}, "stat_wr_ok");
    endtask

    initial begin
        rst_n = 1'b0; wp_n = 1'b1; mem_addr = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_all("R1", 8'h00, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            {wen_set, wen_clr, stat_wr} = v[VW-1 -: 3];
            stat_wdata = v[VW-4 -: 8];
            wp_n       = v[VW-12];
            mem_addr   = v[VW-13 -: ADDR_W];
            @(negedge clk);
            idle_inputs();
            check_all(vec_req(i), v[9:2], v[1], v[0]);
        end

        // R2: user bits alone do not change permits (latch set, code 00, lock clear)
        wen_set = 1'b1; @(negedge clk); idle_inputs();
        stat_wr = 1'b1; stat_wdata = 8'h71; wp_n = 1'b0; mem_addr = 17'h1FFFF;
        @(negedge clk); idle_inputs();
        check_all("R2", 8'h73, 1'b1, 1'b1);

        // R7: write-protect sampled on the strobe cycle only
        stat_wr = 1'b1; stat_wdata = 8'h80; wp_n = 1'b1;
        @(negedge clk); idle_inputs();
        stat_wr = 1'b1; stat_wdata = 8'h84; wp_n = 1'b0;
        @(negedge clk); idle_inputs(); wp_n = 1'b1;
        @(negedge clk);
        check("R7", stat_q, 8'h82, "status after low-input write");

        // R1: reset mid-run returns everything to zero
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check_all("R1", 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule